// File: doc/BRIEF.md
# Sequential 64-by-32 Integer Divider with Range Faults

This block divides a 64-bit dividend by a 32-bit divisor and returns a 32-bit quotient and a 32-bit remainder. The dividend arrives as two 32-bit words. The upper word forms bits 63..32 and the lower word forms bits 31..0. A mode input selects unsigned arithmetic or two's-complement arithmetic. In signed mode the dividend is read as a 64-bit signed value and the divisor as a 32-bit signed value. The quotient truncates toward zero, and the remainder carries the sign of the dividend.

The block refuses any division that cannot give a valid 32-bit result. In these cases it raises a fault flag together with its completion pulse, and it leaves both result outputs untouched. The fault cases are:
- a zero divisor;
- a quotient that does not fit in 32 bits (unsigned), or does not fit in the signed 32-bit range (signed);
- the most negative 64-bit dividend divided by minus one (signed).

A caller raises `start` for one cycle while the block is idle and then waits for `done`. The core is a restoring shift-subtract loop that works on magnitudes. It runs one quotient bit per cycle. One more cycle applies the signs and the range check. Faults that are visible from the operands alone are reported in the cycle after `start`. These are the zero divisor, the most-negative-by-minus-one case and, by default, an unsigned upper word at or above the divisor.

Top module: `longdiv_unit`

## Requirements
- R1: In unsigned mode (`signed_mode`=0), with dividend {`dvd_hi`,`dvd_lo`} and a nonzero divisor whose quotient fits in 32 bits, `done` brings `quo` = dividend / divisor and `rem` = dividend mod divisor.
- R2: A divisor of zero, in either mode, gives `done`=1 and `fault`=1 in the cycle after `start` is accepted.
- R3: In unsigned mode, a quotient of 2^32 or more (for example `dvd_hi` >= `dvsr`) ends with `done`=1 and `fault`=1.
- R4: In signed mode (`signed_mode`=1), with a quotient inside [-2^31, 2^31-1], the quotient truncates toward zero and the remainder is zero or has the sign of the dividend. Both are given as 32-bit two's complement.
- R5: In signed mode, a quotient above 2^31-1 or below -2^31 ends with `done`=1 and `fault`=1.
- R6: In signed mode, dividend 0x8000000000000000 with divisor 0xFFFFFFFF gives `done`=1 and `fault`=1 in the cycle after `start`.
- R7: When `fault` is reported, `quo` and `rem` keep the values of the last successful division (zero after reset).
- R8: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted non-faulting `start` until the cycle that shows `done`. A `start` while `busy` is ignored and does not affect the running division.
- R9: After reset, `busy`, `done` and `fault` are 0 and `quo` and `rem` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled only while idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dvd_hi | input | 32 | Upper word of the dividend |
| dvd_lo | input | 32 | Lower word of the dividend |
| dvsr | input | 32 | Divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Valid with `done`: the division was refused |
| quo | output | 32 | Quotient of the last successful division |
| rem | output | 32 | Remainder of the last successful division |

## Verification
The bound checker watches several properties on every cycle:
- the single-cycle width of `done` and its exclusion with `busy`;
- the next-cycle fault for a zero divisor and for the most-negative-by-minus-one case;
- that result outputs stay frozen on any fault;
- that an unsigned remainder lies below the captured divisor;
- that a signed nonzero remainder has the captured dividend's sign.

The exact quotient and remainder values, faults that come from the range check, and the ignoring of a second `start` while busy can only be shown by the bench. It compares every completion against a 64-bit behavioural model. Its scenarios include upper words at and above the divisor, divisors of plus and minus one, quotients exactly at the signed limits, and directed and pseudo-random operands in both modes.

// File: rtl/longdiv_pkg.sv
package longdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } div_state_e;

endpackage

// File: rtl/longdiv_prep.sv
// Operand conditioning: magnitudes, sign flags and faults visible at start.
module longdiv_prep #(
   parameter int DW          = 32,
   parameter bit EARLY_RANGE = 1'b1
) (
   input  logic            signed_mode,
   input  logic [DW-1:0]   dvd_hi,
   input  logic [DW-1:0]   dvd_lo,
   input  logic [DW-1:0]   dvsr,
   output logic [2*DW-1:0] dvd_mag,
   output logic [DW-1:0]   dvsr_mag,
   output logic            dvd_neg,
   output logic            dvsr_neg,
   output logic            start_fault
);

   localparam int WW = 2 * DW;
   localparam logic [WW-1:0] MOST_NEG = {1'b1, {(WW-1){1'b0}}};

   logic [WW-1:0] dvd_full;
   logic          zero_dvsr;
   logic          min_by_neg1;
   logic          range_early;

   assign dvd_full  = {dvd_hi, dvd_lo};
   assign dvd_neg   = signed_mode & dvd_full[WW-1];
   assign dvsr_neg  = signed_mode & dvsr[DW-1];
   assign dvd_mag   = dvd_neg  ? (~dvd_full + 1'b1) : dvd_full;
   assign dvsr_mag  = dvsr_neg ? (~dvsr + 1'b1)     : dvsr;

   assign zero_dvsr   = (dvsr == '0);
   assign min_by_neg1 = signed_mode && (dvd_full == MOST_NEG) && (dvsr == '1);

   generate
      if (EARLY_RANGE) begin : g_early
         // Unsigned quotient overflows exactly when the upper word reaches the divisor.
         assign range_early = !signed_mode && (dvd_hi >= dvsr);
      end else begin : g_late
         assign range_early = 1'b0;
      end
   endgenerate

   assign start_fault = zero_dvsr | min_by_neg1 | range_early;

endmodule

// File: rtl/longdiv_core.sv
// Restoring shift-subtract loop on magnitudes, one quotient bit per step.
module longdiv_core #(
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic [2*DW-1:0] dvd_mag,
   input  logic [DW-1:0]   dvsr_mag,
   output logic [2*DW-1:0] q_mag,
   output logic [DW-1:0]   r_mag
);

   localparam int WW = 2 * DW;

   logic [WW-1:0] shreg;
   logic [DW-1:0] part_rem;
   logic [DW-1:0] dvsr_q;
   logic [DW:0]   trial;
   logic [DW:0]   diff;
   logic          take;

   assign trial = {part_rem, shreg[WW-1]};
   assign diff  = trial - {1'b0, dvsr_q};
   assign take  = ~diff[DW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         part_rem <= '0;
         dvsr_q   <= '0;
      end else if (load) begin
         shreg    <= dvd_mag;
         part_rem <= '0;
         dvsr_q   <= dvsr_mag;
      end else if (step) begin
         shreg    <= {shreg[WW-2:0], take};
         part_rem <= take ? diff[DW-1:0] : trial[DW-1:0];
      end
   end

   assign q_mag = shreg;
   assign r_mag = part_rem;

endmodule

// File: rtl/longdiv_fix.sv
// Sign restoration and final range check on the raw magnitudes.
module longdiv_fix #(
   parameter int DW = 32
) (
   input  logic            mode_s,
   input  logic            dvd_neg,
   input  logic            dvsr_neg,
   input  logic [2*DW-1:0] q_mag,
   input  logic [DW-1:0]   r_mag,
   output logic [DW-1:0]   quo_fixed,
   output logic [DW-1:0]   rem_fixed,
   output logic            range_fault
);

   localparam logic [DW-1:0] NEG_LIMIT = {1'b1, {(DW-1){1'b0}}};

   logic          upper_zero;
   logic          q_neg;
   logic [DW-1:0] q_low;

   assign upper_zero = (q_mag[2*DW-1:DW] == '0);
   assign q_low      = q_mag[DW-1:0];
   assign q_neg      = mode_s & (dvd_neg ^ dvsr_neg);

   always_comb begin
      if (!mode_s)
         range_fault = !upper_zero;
      else if (q_neg)
         range_fault = !upper_zero || (q_low > NEG_LIMIT);
      else
         range_fault = !upper_zero || q_low[DW-1];
   end

   assign quo_fixed = q_neg   ? (~q_low + 1'b1) : q_low;
   assign rem_fixed = dvd_neg ? (~r_mag + 1'b1) : r_mag;

endmodule

// File: rtl/longdiv_unit.sv
module longdiv_unit #(
   parameter int DW          = 32,
   parameter bit EARLY_RANGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          signed_mode,
   input  logic [DW-1:0] dvd_hi,
   input  logic [DW-1:0] dvd_lo,
   input  logic [DW-1:0] dvsr,
   output logic          busy,
   output logic          done,
   output logic          fault,
   output logic [DW-1:0] quo,
   output logic [DW-1:0] rem
);

   import longdiv_pkg::*;

   localparam int WW    = 2 * DW;
   localparam int CNT_W = $clog2(WW);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WW - 1);

   generate
      if (DW < 4) begin : g_bad_width
         $error("longdiv_unit: DW must be at least 4");
      end
   endgenerate

   div_state_e       state;
   logic [CNT_W-1:0] step_cnt;
   logic             mode_q, dvd_neg_q, dvsr_neg_q;
   logic             done_q, fault_q;
   logic [DW-1:0]    quo_q, rem_q;

   logic [WW-1:0]    dvd_mag;
   logic [DW-1:0]    dvsr_mag;
   logic             dvd_neg, dvsr_neg, start_fault;
   logic [WW-1:0]    q_mag;
   logic [DW-1:0]    r_mag;
   logic [DW-1:0]    quo_fixed, rem_fixed;
   logic             range_fault;
   logic             accept, load, step;

   longdiv_prep #(.DW(DW), .EARLY_RANGE(EARLY_RANGE)) u_prep (
      .signed_mode (signed_mode),
      .dvd_hi      (dvd_hi),
      .dvd_lo      (dvd_lo),
      .dvsr        (dvsr),
      .dvd_mag     (dvd_mag),
      .dvsr_mag    (dvsr_mag),
      .dvd_neg     (dvd_neg),
      .dvsr_neg    (dvsr_neg),
      .start_fault (start_fault)
   );

   assign accept = (state == ST_IDLE) && start;
   assign load   = accept && !start_fault;
   assign step   = (state == ST_RUN);

   longdiv_core #(.DW(DW)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .dvd_mag  (dvd_mag),
      .dvsr_mag (dvsr_mag),
      .q_mag    (q_mag),
      .r_mag    (r_mag)
   );

   longdiv_fix #(.DW(DW)) u_fix (
      .mode_s      (mode_q),
      .dvd_neg     (dvd_neg_q),
      .dvsr_neg    (dvsr_neg_q),
      .q_mag       (q_mag),
      .r_mag       (r_mag),
      .quo_fixed   (quo_fixed),
      .rem_fixed   (rem_fixed),
      .range_fault (range_fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         step_cnt   <= '0;
         mode_q     <= 1'b0;
         dvd_neg_q  <= 1'b0;
         dvsr_neg_q <= 1'b0;
         done_q     <= 1'b0;
         fault_q    <= 1'b0;
         quo_q      <= '0;
         rem_q      <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (start_fault) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                  end else begin
                     state      <= ST_RUN;
                     step_cnt   <= '0;
                     mode_q     <= signed_mode;
                     dvd_neg_q  <= dvd_neg;
                     dvsr_neg_q <= dvsr_neg;
                  end
               end
            end
            ST_RUN: begin
               step_cnt <= step_cnt + 1'b1;
               if (step_cnt == LAST_STEP)
                  state <= ST_FIX;
            end
            ST_FIX: begin
               done_q <= 1'b1;
               state  <= ST_IDLE;
               if (range_fault) begin
                  fault_q <= 1'b1;
               end else begin
                  quo_q <= quo_fixed;
                  rem_q <= rem_fixed;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (state != ST_IDLE);
   assign done  = done_q;
   assign fault = fault_q;
   assign quo   = quo_q;
   assign rem   = rem_q;

endmodule

// File: rtl/longdiv_chk.sv
module longdiv_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          signed_mode,
   input logic [DW-1:0] dvd_hi,
   input logic [DW-1:0] dvd_lo,
   input logic [DW-1:0] dvsr,
   input logic          busy,
   input logic          done,
   input logic          fault,
   input logic [DW-1:0] quo,
   input logic [DW-1:0] rem
);

   localparam logic [DW-1:0] TOP_ONLY = {1'b1, {(DW-1){1'b0}}};

   logic          cap_mode;
   logic          cap_dvd_neg;
   logic [DW-1:0] cap_dvsr;
   logic [DW-1:0] quo_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_mode    <= 1'b0;
         cap_dvd_neg <= 1'b0;
         cap_dvsr    <= '0;
      end else if (start && !busy) begin
         cap_mode    <= signed_mode;
         cap_dvd_neg <= dvd_hi[DW-1];
         cap_dvsr    <= dvsr;
      end
   end

   assign quo_seen = quo;

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_fault_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);

   assert_zero_divisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && dvsr == '0) |=> (done && fault));

   assert_most_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && signed_mode && dvd_hi == TOP_ONLY && dvd_lo == '0 && dvsr == '1)
      |=> (done && fault));

   assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> ($stable(quo_seen) && $stable(rem)));

   assert_rem_below_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && !cap_mode) |-> (rem < cap_dvsr));

   assert_rem_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && cap_mode && rem != '0) |-> (rem[DW-1] == cap_dvd_neg));

endmodule

bind longdiv_unit longdiv_chk #(.DW(DW)) u_longdiv_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .signed_mode (signed_mode),
   .dvd_hi      (dvd_hi),
   .dvd_lo      (dvd_lo),
   .dvsr        (dvsr),
   .busy        (busy),
   .done        (done),
   .fault       (fault),
   .quo         (quo),
   .rem         (rem)
);

// File: tb/test_longdiv_unit.sv
`timescale 1ns/1ps
module test_longdiv_unit;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          signed_mode = 1'b0;
   logic [DW-1:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
   logic          busy, done, fault;
   logic [DW-1:0] quo, rem;

   always #2 clk = ~clk;

   longdiv_unit #(.DW(DW)) i_longdiv_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
      .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
      .busy(busy), .done(done), .fault(fault), .quo(quo), .rem(rem)
   );

   typedef struct {
      logic          flt;
      logic [DW-1:0] q;
      logic [DW-1:0] r;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int n_checks = 0;
   int n_fail   = 0;
   int issued   = 0;
   int retired  = 0;
   logic [DW-1:0] model_q = '0, model_r = '0;
   logic [63:0]   rng = 64'h9E3779B97F4A7C15;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Behavioural model of one division.
   task automatic model(input logic sm, input logic [DW-1:0] hi, input logic [DW-1:0] lo,
                        input logic [DW-1:0] d, output exp_t e);
      logic signed [63:0] sa, sb_, sq, sr;
      logic [63:0] ua, uq, ur;
      e.flt = 1'b0;
      if (d == '0) begin
         e.flt = 1'b1;
      end else if (!sm) begin
         ua = {hi, lo};
         uq = ua / {32'd0, d};
         ur = ua % {32'd0, d};
         if (uq[63:32] != 0) e.flt = 1'b1;
         else begin model_q = uq[31:0]; model_r = ur[31:0]; end
      end else begin
         sa  = $signed({hi, lo});
         sb_ = $signed({{32{d[31]}}, d});
         if (sa == 64'sh8000000000000000 && sb_ == -64'sd1) e.flt = 1'b1;
         else begin
            sq = sa / sb_;
            sr = sa % sb_;
            if (sq > 64'sd2147483647 || sq < -64'sd2147483648) e.flt = 1'b1;
            else begin model_q = sq[31:0]; model_r = sr[31:0]; end
         end
      end
      e.q = model_q;
      e.r = model_r;
   endtask

   task automatic run_op(input logic sm, input logic [DW-1:0] hi, input logic [DW-1:0] lo,
                         input logic [DW-1:0] d, input string tag);
      exp_t e;
      bit quick;
      model(sm, hi, lo, d, e);
      e.tag = tag;
      sb.push_back(e);
      quick = (d == '0) || (sm && hi == 32'h80000000 && lo == '0 && d == '1);
      @(negedge clk);
      while (busy) @(negedge clk);
      signed_mode = sm; dvd_hi = hi; dvd_lo = lo; dvsr = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      issued++;
      if (quick)
         chk(done && fault, tag, "next-cycle fault", {30'd0, done, fault}, 32'd3);
      wait (retired == issued);
   endtask

   // Monitor: pop and compare each completion.
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R8", "unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(fault == e.flt, e.tag, "fault", {31'd0, fault}, {31'd0, e.flt});
            chk(quo == e.q, e.tag, "quo", quo, e.q);
            chk(rem == e.r, e.tag, "rem", rem, e.r);
         end
         retired++;
      end
   end

   function automatic logic [63:0] next_rng(input logic [63:0] s);
      logic [63:0] x;
      x = s;
      x ^= x << 13;
      x ^= x >> 7;
      x ^= x << 17;
      return x;
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(!busy && !done && !fault, "R9", "flags", {29'd0, busy, done, fault}, 32'd0);
      chk(quo == '0 && rem == '0, "R9", "results", quo | rem, 32'd0);

      // R1 unsigned
      run_op(1'b0, 32'd0, 32'd100, 32'd7, "R1");
      run_op(1'b0, 32'd5, 32'h12345678, 32'd6, "R1");
      run_op(1'b0, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1");
      run_op(1'b0, 32'd0, 32'hDEADBEEF, 32'd1, "R1");
      run_op(1'b0, 32'd0, 32'd3, 32'd9, "R1");
      // R3 unsigned overflow
      run_op(1'b0, 32'd6, 32'd0, 32'd6, "R3");
      run_op(1'b0, 32'd1, 32'd0, 32'd1, "R3");
      run_op(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, "R3");
      // R2 zero divisor, both modes; R7 results held
      run_op(1'b0, 32'd0, 32'd55, 32'd0, "R2");
      run_op(1'b1, 32'hFFFFFFFF, 32'hFFFFFFF0, 32'd0, "R2_R7");
      // R4 signed
      run_op(1'b1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'd7, "R4");
      run_op(1'b1, 32'd0, 32'd100, 32'hFFFFFFF9, "R4");
      run_op(1'b1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'hFFFFFFF9, "R4");
      run_op(1'b1, 32'd0, 32'd5, 32'hFFFFFFFF, "R4");
      run_op(1'b1, 32'hFFFFFFFF, 32'h80000000, 32'd1, "R4");
      run_op(1'b1, 32'hFFFFFFFE, 32'h80000000, 32'd3, "R4");
      // R5 signed range
      run_op(1'b1, 32'd1, 32'h80000000, 32'd3, "R5_R7");
      run_op(1'b1, 32'h80000000, 32'd0, 32'd1, "R5");
      run_op(1'b1, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF, "R5");
      // R6 most negative by minus one
      run_op(1'b1, 32'h80000000, 32'd0, 32'hFFFFFFFF, "R6_R7");

      // R8: start while busy ignored (a zero divisor there would fault)
      begin
         exp_t e;
         model(1'b0, 32'd0, 32'd1000, 32'd3, e);
         e.tag = "R8";
         sb.push_back(e);
         @(negedge clk);
         signed_mode = 1'b0; dvd_hi = 0; dvd_lo = 32'd1000; dvsr = 32'd3; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         issued++;
         chk(busy, "R8", "busy after start", {31'd0, busy}, 32'd1);
         repeat (5) @(negedge clk);
         dvsr = 32'd0; dvd_lo = 32'd7; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait (retired == issued);
      end

      // Pseudo-random mix in both modes
      for (int i = 0; i < 24; i++) begin
         logic [DW-1:0] lo, hi, d;
         rng = next_rng(rng); lo = rng[31:0]; d = rng[63:32] >> (i % 20);
         rng = next_rng(rng);
         if (i % 2 == 0) begin
            hi = (i % 4 == 0) ? {32{lo[31]}} : rng[31:0] >> 3;
            run_op(1'b1, hi, lo, d, "R4");
         end else begin
            hi = rng[31:0] % (d + 32'd1);
            run_op(1'b0, hi, lo, d, "R1");
         end
      end

      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 32'd0);
      finish_run();
   end

endmodule